// File: doc/BRIEF.md
# Slot-scheduled shared word RAM arbiter

This block shares one single-port data RAM of 1024 words by 32 bits among three requesters: a microprocessor, a computation engine and an SPI host. A free-running four-slot schedule hands out the RAM port in a fixed order. Two slots belong to the microprocessor, one to the engine and one to the SPI host. Each requester therefore gets a known share of bandwidth and a bounded latency, and no requester can starve another.

The microprocessor sees the RAM as byte-wide memory. Its byte address is split into a lane select and a word index. A byte read returns one lane of the word. A byte write is a read-modify-write. The word is read in the first microprocessor slot, the new byte is merged in, and the whole word is written back in the second microprocessor slot of the same period. The engine and the SPI host always transfer whole 32-bit words.

Every requester uses the same handshake. It holds its request, direction, address and write data until a one-cycle ready pulse comes back. It then drops the request before its next slot comes round.

Top module: `wram_slot_arbiter`

## Requirements
- R1: After reset the slot index starts at 0 and advances by one every clock, modulo 4. Slot 0 is microprocessor access A, slot 1 is the engine, slot 2 is microprocessor access B and slot 3 is SPI. Every port request is served in the next slot of its kind that starts on or after the cycle in which the request is first seen.
- R2: An engine request is served in slot 1. `eng_rdy` pulses in the following cycle. On a read, `eng_rdata` holds the addressed 32-bit word in that same cycle. On a write, the word at `eng_addr` takes the value of `eng_wdata`.
- R3: An SPI request is served in slot 3 and `spi_rdy` pulses in the following cycle. It has the same read and write meaning as the engine port.
- R4: A microprocessor read is served in slot 0 and `mpu_rdy` pulses in the following cycle. Byte address bits [1:0] select the lane, where lane n is word bits [8n+7:8n], and bits [11:2] select the word. `mpu_rdata` returns the selected lane.
- R5: A microprocessor write reads the word in slot 0 and writes the merged word in the slot 2 of the same period. `mpu_rdy` pulses in the cycle after that write. Only the addressed lane changes, and the other three bytes keep their old values.
- R6: A microprocessor read of any lane of a word that a byte write has just completed returns the merged contents.
- R7: A request raised outside its slot waits with no ready pulse until its slot arrives. Each served access gives exactly one one-cycle ready pulse, and at most one ready output is high in any cycle.
- R8: While reset is held, and in the first cycle after it, all ready outputs are low. With no request pending, no ready is ever asserted.
- R9: All three ports address the same storage. A word written through any port is seen by reads from the other ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mpu_req | input | 1 | Microprocessor request, held until `mpu_rdy` |
| mpu_we | input | 1 | Microprocessor write (1) or read (0) |
| mpu_addr | input | ADDR_W+2 | Microprocessor byte address |
| mpu_wdata | input | 8 | Microprocessor write byte |
| mpu_rdy | output | 1 | Microprocessor access complete, one cycle |
| mpu_rdata | output | 8 | Microprocessor read byte, valid with `mpu_rdy` on a read |
| eng_req | input | 1 | Engine request |
| eng_we | input | 1 | Engine write (1) or read (0) |
| eng_addr | input | ADDR_W | Engine word address |
| eng_wdata | input | 32 | Engine write word |
| eng_rdy | output | 1 | Engine access complete |
| eng_rdata | output | 32 | Engine read word, valid with `eng_rdy` on a read |
| spi_req | input | 1 | SPI host request |
| spi_we | input | 1 | SPI write (1) or read (0) |
| spi_addr | input | ADDR_W | SPI word address |
| spi_wdata | input | 32 | SPI write word |
| spi_rdy | output | 1 | SPI access complete |
| spi_rdata | output | 32 | SPI read word, valid with `spi_rdy` on a read |

## Verification
The bench builds the block with ADDR_W = 4, which gives 16 words and 64 byte addresses, and keeps the 32-bit word and 8-bit lane. At that size every word can be filled through SPI and read back through the engine, and every byte address can be read and byte-written through the microprocessor port. The bench reads the neighbouring lanes after each merge. It counts its own cycles from reset, so each request is raised at every one of the four slot phases and its ready cycle is predicted by plain modular arithmetic.

// File: rtl/wram_pkg.sv
// Shared types for the slot-scheduled word RAM arbiter.
// Assumes a fixed four-slot schedule; slot codes are the schedule order.
package wram_pkg;

    typedef enum logic [1:0] {
        SLOT_MPU_A = 2'd0,
        SLOT_ENG   = 2'd1,
        SLOT_MPU_B = 2'd2,
        SLOT_SPI   = 2'd3
    } slot_e;

    typedef enum logic [2:0] {
        OWN_NONE    = 3'd0,
        OWN_MPU_RD  = 3'd1,
        OWN_MPU_RMW = 3'd2,
        OWN_MPU_WR  = 3'd3,
        OWN_ENG     = 3'd4,
        OWN_SPI     = 3'd5
    } owner_e;

endpackage

// File: rtl/wram_slot_sched.sv
// Free-running slot counter for the shared RAM.
// Assumes the schedule length is four; it wraps by natural overflow.
module wram_slot_sched
    import wram_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);

    // advance one slot per clock, restart at slot 0 on reset
    always_ff @(posedge clk) begin
        if (!rst_n) slot <= SLOT_MPU_A;
        else        slot <= slot_e'(slot + 2'd1);
    end

endmodule

// File: rtl/wram_lane_mux.sv
// Byte-lane access to a RAM word: extracts one lane and builds the word
// with one lane replaced. Purely combinational.
// Assumes DATA_W is a whole multiple of LANE_W.
module wram_lane_mux #(
    parameter int DATA_W = 32,
    parameter int LANE_W = 8,
    parameter int LANES  = DATA_W / LANE_W,
    parameter int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic [DATA_W-1:0] word,
    input  logic [LSEL_W-1:0] lane,
    input  logic [LANE_W-1:0] new_byte,
    output logic [LANE_W-1:0] rd_byte,
    output logic [DATA_W-1:0] merged
);

    // pick the addressed lane out of the word
    assign rd_byte = word[lane*LANE_W +: LANE_W];

    // replace only the addressed lane, keep the others
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign merged[g*LANE_W +: LANE_W] =
            (lane == LSEL_W'(g)) ? new_byte : word[g*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/wram_store.sv
// Behavioural single-port RAM with a registered read.
// Assumes one access per cycle; a write leaves the read register unchanged.
module wram_store #(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    // one read or one write per enabled cycle
    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            else    rdata     <= mem[addr];
        end
    end

endmodule

// File: rtl/wram_slot_arbiter.sv
// Time-multiplexed arbiter for a shared word RAM. Slot order: microprocessor
// A, engine, microprocessor B, SPI. Microprocessor byte writes read in slot A
// and write the merged word in slot B.
// Assumes every requester holds its request until ready and drops it in the
// ready cycle, and the microprocessor issues at most one access per period.
module wram_slot_arbiter
    import wram_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32,
    parameter int LANE_W = 8
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      mpu_req,
    input  logic                                      mpu_we,
    input  logic [ADDR_W+$clog2(DATA_W/LANE_W)-1:0]   mpu_addr,
    input  logic [LANE_W-1:0]                         mpu_wdata,
    output logic                                      mpu_rdy,
    output logic [LANE_W-1:0]                         mpu_rdata,
    input  logic                                      eng_req,
    input  logic                                      eng_we,
    input  logic [ADDR_W-1:0]                         eng_addr,
    input  logic [DATA_W-1:0]                         eng_wdata,
    output logic                                      eng_rdy,
    output logic [DATA_W-1:0]                         eng_rdata,
    input  logic                                      spi_req,
    input  logic                                      spi_we,
    input  logic [ADDR_W-1:0]                         spi_addr,
    input  logic [DATA_W-1:0]                         spi_wdata,
    output logic                                      spi_rdy,
    output logic [DATA_W-1:0]                         spi_rdata
);

    localparam int LANES  = DATA_W / LANE_W;
    localparam int LSEL_W = $clog2(LANES);

    slot_e              slot_q;
    owner_e             owner_q, owner_d;
    logic               ram_en, ram_we;
    logic [ADDR_W-1:0]  ram_addr;
    logic [DATA_W-1:0]  ram_wd, ram_rd;
    logic [ADDR_W-1:0]  mpu_word_q;
    logic [LSEL_W-1:0]  mpu_lane_q;
    logic [LANE_W-1:0]  mpu_byte_q;
    logic [DATA_W-1:0]  merged_q, merged_w;
    logic               wr_pend_q;
    logic [LANE_W-1:0]  lane_byte;

    wram_slot_sched u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (slot_q)
    );

    wram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk   (clk),
        .en    (ram_en),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wd),
        .rdata (ram_rd)
    );

    wram_lane_mux #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lane (
        .word     (ram_rd),
        .lane     (mpu_lane_q),
        .new_byte (mpu_byte_q),
        .rd_byte  (lane_byte),
        .merged   (merged_w)
    );

    // give the RAM port to the owner of the current slot, if it asks
    always_comb begin
        ram_en   = 1'b0;
        ram_we   = 1'b0;
        ram_addr = '0;
        ram_wd   = '0;
        owner_d  = OWN_NONE;
        unique case (slot_q)
            SLOT_MPU_A: if (mpu_req) begin
                ram_en   = 1'b1;
                ram_addr = mpu_addr[LSEL_W +: ADDR_W];
                owner_d  = mpu_we ? OWN_MPU_RMW : OWN_MPU_RD;
            end
            SLOT_ENG: if (eng_req) begin
                ram_en   = 1'b1;
                ram_we   = eng_we;
                ram_addr = eng_addr;
                ram_wd   = eng_wdata;
                owner_d  = OWN_ENG;
            end
            SLOT_MPU_B: if (wr_pend_q) begin
                ram_en   = 1'b1;
                ram_we   = 1'b1;
                ram_addr = mpu_word_q;
                ram_wd   = merged_q;
                owner_d  = OWN_MPU_WR;
            end
            SLOT_SPI: if (spi_req) begin
                ram_en   = 1'b1;
                ram_we   = spi_we;
                ram_addr = spi_addr;
                ram_wd   = spi_wdata;
                owner_d  = OWN_SPI;
            end
            default: ;
        endcase
    end

    // remember who used the RAM last cycle, so its result goes back to it
    always_ff @(posedge clk) begin
        if (!rst_n) owner_q <= OWN_NONE;
        else        owner_q <= owner_d;
    end

    // latch the microprocessor address and byte when its slot A is taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mpu_word_q <= '0;
            mpu_lane_q <= '0;
            mpu_byte_q <= '0;
        end else if (slot_q == SLOT_MPU_A && mpu_req) begin
            mpu_word_q <= mpu_addr[LSEL_W +: ADDR_W];
            mpu_lane_q <= mpu_addr[LSEL_W-1:0];
            mpu_byte_q <= mpu_wdata;
        end
    end

    // hold the merged word from the read half until slot B writes it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            merged_q  <= '0;
            wr_pend_q <= 1'b0;
        end else if (owner_q == OWN_MPU_RMW) begin
            merged_q  <= merged_w;
            wr_pend_q <= 1'b1;
        end else if (owner_d == OWN_MPU_WR) begin
            wr_pend_q <= 1'b0;
        end
    end

    // completions: one ready per served access, in the cycle after it
    assign mpu_rdy   = (owner_q == OWN_MPU_RD) || (owner_q == OWN_MPU_WR);
    assign mpu_rdata = lane_byte;
    assign eng_rdy   = (owner_q == OWN_ENG);
    assign eng_rdata = ram_rd;
    assign spi_rdy   = (owner_q == OWN_SPI);
    assign spi_rdata = ram_rd;

endmodule

// File: rtl/wram_arb_checker.sv
// Timing and schedule properties of the shared RAM arbiter.
// Attached to every instance of the top module by the bind below.
module wram_arb_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] slot,
    input logic       mpu_we,
    input logic       mpu_rdy,
    input logic       eng_rdy,
    input logic       spi_rdy,
    input logic       ram_en,
    input logic       ram_we
);

    // slot B is only ever used for the write half of a byte write
    assert_slot_b_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_en && slot == 2'd2) |-> ram_we);

    // engine completion follows an engine slot
    assert_eng_after_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rdy |-> slot == 2'd2);

    // SPI completion follows an SPI slot
    assert_spi_after_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        spi_rdy |-> slot == 2'd0);

    // byte read completes right after slot A
    assert_mpu_read_timing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mpu_rdy && !mpu_we) |-> slot == 2'd1);

    // byte write completes right after slot B
    assert_mpu_write_timing_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mpu_rdy && mpu_we) |-> slot == 2'd3);

    // at most one completion per cycle
    assert_single_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({mpu_rdy, eng_rdy, spi_rdy}) <= 1);

    // engine and SPI ready are single-cycle pulses
    assert_eng_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        eng_rdy |=> !eng_rdy);
    assert_spi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        spi_rdy |=> !spi_rdy);

    // the slot index steps by one each clock
    assert_slot_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> slot == 2'($past(slot) + 2'd1));

endmodule

bind wram_slot_arbiter wram_arb_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot    (slot_q),
    .mpu_we  (mpu_we),
    .mpu_rdy (mpu_rdy),
    .eng_rdy (eng_rdy),
    .spi_rdy (spi_rdy),
    .ram_en  (ram_en),
    .ram_we  (ram_we)
);

// File: tb/sim_wram_slot_arbiter.sv
// Sweep bench for the slot arbiter on a 16-word configuration.
module sim_wram_slot_arbiter;

    localparam int AW = 4;
    localparam int NW = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mpu_req = 1'b0, mpu_we = 1'b0;
    logic [AW+1:0] mpu_addr = '0;
    logic [7:0]  mpu_wdata = '0;
    logic        mpu_rdy;
    logic [7:0]  mpu_rdata;
    logic        eng_req = 1'b0, eng_we = 1'b0;
    logic [AW-1:0] eng_addr = '0;
    logic [31:0] eng_wdata = '0;
    logic        eng_rdy;
    logic [31:0] eng_rdata;
    logic        spi_req = 1'b0, spi_we = 1'b0;
    logic [AW-1:0] spi_addr = '0;
    logic [31:0] spi_wdata = '0;
    logic        spi_rdy;
    logic [31:0] spi_rdata;

    int total = 0;
    int bad = 0;
    int k = 0;
    logic [31:0] refm [NW];

    always #2 clk = ~clk;

    // edges counted since reset release; slot during interval k is k mod 4
    always @(posedge clk) begin
        if (!rst_n) k <= 0;
        else        k <= k + 1;
    end

    wram_slot_arbiter #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .mpu_req(mpu_req), .mpu_we(mpu_we), .mpu_addr(mpu_addr),
        .mpu_wdata(mpu_wdata), .mpu_rdy(mpu_rdy), .mpu_rdata(mpu_rdata),
        .eng_req(eng_req), .eng_we(eng_we), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rdy(eng_rdy), .eng_rdata(eng_rdata),
        .spi_req(spi_req), .spi_we(spi_we), .spi_addr(spi_addr),
        .spi_wdata(spi_wdata), .spi_rdy(spi_rdy), .spi_rdata(spi_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready interval: first slot tgt at or after k0, plus lat
    function automatic int exp_rdy(input int k0, input int tgt, input int lat);
        int j = k0;
        while (j % 4 != tgt) j++;
        return j + lat;
    endfunction

    // one access on port p (0 mpu, 1 engine, 2 spi); checks ready cycle
    task automatic access(input int p, input bit we, input int addr, input logic [31:0] wd,
                          output logic [31:0] rd, input string tag);
        int k0, tgt, lat, n;
        bit got;
        @(negedge clk);
        k0 = k;
        case (p)
            0: begin mpu_req = 1; mpu_we = we; mpu_addr = (AW+2)'(addr); mpu_wdata = wd[7:0];
                     tgt = 0; lat = we ? 3 : 1; end
            1: begin eng_req = 1; eng_we = we; eng_addr = AW'(addr); eng_wdata = wd;
                     tgt = 1; lat = 1; end
            default: begin spi_req = 1; spi_we = we; spi_addr = AW'(addr); spi_wdata = wd;
                     tgt = 3; lat = 1; end
        endcase
        got = 0;
        n = 0;
        rd = '0;
        while (!got && n < 20) begin
            @(negedge clk);
            n++;
            case (p)
                0: got = mpu_rdy;
                1: got = eng_rdy;
                default: got = spi_rdy;
            endcase
        end
        case (p)
            0: rd = {24'h0, mpu_rdata};
            1: rd = eng_rdata;
            default: rd = spi_rdata;
        endcase
        chk(got && k == exp_rdy(k0, tgt, lat), {tag, " ready cycle"}, k, exp_rdy(k0, tgt, lat));
        mpu_req = 0; eng_req = 0; spi_req = 0;
    endtask

    initial begin
        #400000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0] b;
        // R8: quiet during reset and first cycle after
        repeat (3) @(negedge clk);
        chk({mpu_rdy, eng_rdy, spi_rdy} == 3'b0, "R8 reset", {29'h0, mpu_rdy, eng_rdy, spi_rdy}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({mpu_rdy, eng_rdy, spi_rdy} == 3'b0, "R8 post reset", {29'h0, mpu_rdy, eng_rdy, spi_rdy}, 0);
        // R8: idle cycles give no ready
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            chk({mpu_rdy, eng_rdy, spi_rdy} == 3'b0, "R8 idle", {29'h0, mpu_rdy, eng_rdy, spi_rdy}, 0);
        end
        // R3 R9: fill through SPI, idle gap varies the request phase (R1)
        for (int w = 0; w < NW; w++) begin
            refm[w] = 32'hA5C3_0F00 ^ (32'(w) * 32'h0101_0107);
            repeat (w % 4) @(negedge clk);
            access(2, 1, w, refm[w], r, "R3 spi write");
        end
        // R2 R9: engine reads back every word
        for (int w = 0; w < NW; w++) begin
            repeat ((w + 1) % 4) @(negedge clk);
            access(1, 0, w, 0, r, "R2 eng read");
            chk(r == refm[w], "R2 R9 eng read data", r, refm[w]);
        end
        // R4: every byte address through the microprocessor
        for (int a = 0; a < 4 * NW; a++) begin
            repeat (a % 4) @(negedge clk);
            access(0, 0, a, 0, r, "R4 mpu read");
            b = refm[a / 4][(a % 4) * 8 +: 8];
            chk(r[7:0] == b, "R4 mpu read data", r, {24'h0, b});
        end
        // R5 R6: byte write every address, read back it and its neighbour
        for (int a = 0; a < 4 * NW; a++) begin
            b = 8'(a * 37 + 11);
            repeat ((a / 4) % 4) @(negedge clk);
            access(0, 1, a, {24'h0, b}, r, "R5 mpu write");
            refm[a / 4][(a % 4) * 8 +: 8] = b;
            access(0, 0, a, 0, r, "R6 mpu read");
            chk(r[7:0] == b, "R6 read after write", r, {24'h0, b});
            access(0, 0, a ^ 1, 0, r, "R6 mpu read");
            b = refm[a / 4][((a ^ 1) % 4) * 8 +: 8];
            chk(r[7:0] == b, "R5 neighbour lane kept", r, {24'h0, b});
        end
        // R5 R9: whole words seen by SPI after the byte writes
        for (int w = 0; w < NW; w++) begin
            access(2, 0, w, 0, r, "R3 spi read");
            chk(r == refm[w], "R5 R9 spi read data", r, refm[w]);
        end
        // R2 R9: engine write seen by microprocessor lanes
        access(1, 1, 5, 32'h1122_3344, r, "R2 eng write");
        refm[5] = 32'h1122_3344;
        for (int l = 0; l < 4; l++) begin
            access(0, 0, 5 * 4 + l, 0, r, "R4 mpu read");
            chk(r[7:0] == refm[5][l * 8 +: 8], "R9 eng to mpu", r, {24'h0, refm[5][l * 8 +: 8]});
        end
        // R7: ready lasts one cycle
        access(1, 0, 3, 0, r, "R7 eng read");
        @(negedge clk);
        chk(!eng_rdy && !mpu_rdy && !spi_rdy, "R7 ready pulse", {31'h0, eng_rdy}, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule